// File: doc/BRIEF.md
# Parallel ADC Read Controller

This block is the host-side sequencer for an eight-channel, eight-bit converter with a parallel result bus. A user asks for a conversion by pulsing `req` with a channel number. The controller then pulses the active-low start line and waits for the converter's short active-low completion pulse. It reads the result over the parallel bus and hands back the data byte with a one-cycle valid strobe. Every pulse width and wait is counted in system clock cycles and set by a parameter.

The converter latches its multiplexer address when the read strobe falls, so the channel given with a request picks the input for the *next* conversion. The conversion in flight uses the channel set up by the previous read. For this reason each result carries the channel that actually produced it. Three link styles are supported and selected per request. In the full style the controller drives chip-select and read together. In the select-low style chip-select stays low and only read toggles. In the tied style the completion pulse itself drives the converter's select and read inputs, so the controller generates no read strobe and takes the bus when the synchronized completion line rises again.

If no completion edge arrives within a set number of cycles, the controller reports a timeout and returns to idle. A completion line that is already low when the wait begins never counts as a new completion.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and after reset, `adc_convst_n`, `adc_rd_n` and `adc_cs_n` are high; `busy`, `res_valid` and `timeout` are low; the converter is taken to be on channel 0, so the first result reports channel 0.
- R2: A `req` seen while idle raises `busy` on the next cycle. `busy` stays high until the cycle that shows `res_valid` or `timeout`. A `req` made while `busy` is high starts no conversion and changes neither the address nor the result.
- R3: `adc_convst_n` goes low on the cycle after acceptance and stays low for exactly CONV_LOW_CYC cycles.
- R4: In the full style (`link_mode` 0), a falling edge of the synchronized `adc_eoc_n` seen while waiting drives `adc_rd_n` and `adc_cs_n` low together for exactly RD_LOW_CYC cycles; the start and read strobes are never low at the same time.
- R5: `adc_addr` holds the requested channel from the cycle after acceptance through the read's falling edge. `res_chan` reports the address presented during the previous completed read (0 after reset).
- R6: `res_data` equals the value on `adc_db` on the last low cycle of the read strobe (or, in the tied style, when the synchronized completion line rises).
- R7: `res_valid` is a single-cycle pulse that appears exactly RD_GAP_CYC cycles after `adc_rd_n` returns high; `busy` falls in the same cycle.
- R8: In the select-low style (`link_mode` 1), `adc_cs_n` stays low for the whole transaction while `adc_rd_n` alone strobes the read.
- R9: In the tied style (`link_mode` 2), `adc_rd_n` and `adc_cs_n` stay high; the data is taken on the rising edge of the synchronized completion line after its fall, and the result is still returned with `res_valid`.
- R10: If no falling completion edge arrives within TIMEOUT_CYC cycles after `adc_convst_n` rises, `timeout` pulses exactly TIMEOUT_CYC cycles after that rise, no `res_valid` is given, and the reported channel does not advance; a completion line already low before the wait (a falling edge while idle) is ignored.
- R11: `link_mode` is sampled at acceptance; code 3 behaves like code 0, with `adc_cs_n` low during the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Conversion request, taken when idle |
| req_chan | input | CH_W | Channel to present for the following conversion |
| link_mode | input | 2 | 0 full, 1 select held low, 2 completion tied to select/read, 3 as 0 |
| busy | output | 1 | Transaction in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Conversion result |
| res_chan | output | CH_W | Channel that produced `res_data` |
| timeout | output | 1 | One-cycle pulse: no completion seen |
| adc_convst_n | output | 1 | Active-low conversion start |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_rd_n | output | 1 | Active-low read strobe |
| adc_addr | output | CH_W | Multiplexer address to the converter |
| adc_eoc_n | input | 1 | Active-low completion pulse (asynchronous) |
| adc_db | input | DATA_W | Parallel result bus |

## Verification
The bench goes after the one-ahead channel pipeline. A design that reported the requested channel instead of the one latched at the previous read would mislabel every result, and the first result after reset would not read channel 0. It holds the completion line low while idle and then requests. A design that reacted to the level instead of a new falling edge would read stale data instead of timing out. It injects a request in mid-transaction, which a design that does not ignore it would show as a second start pulse or a wrong address at the read edge. It also measures the start, read and gap widths and the timeout distance cycle by cycle, and it checks in the tied style that no read strobe is ever driven.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_READ,
    ST_GAP
  } rd_state_e;

  localparam logic [1:0] LINK_FULL   = 2'd0;
  localparam logic [1:0] LINK_CS_LOW = 2'd1;
  localparam logic [1:0] LINK_TIED   = 2'd2;

endpackage

// File: rtl/eoc_edge_sync.sv
module eoc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic eoc_n_async,
  output logic fall,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], eoc_n_async};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
  assign rise = ~prev_q & sync_q[STAGES-1];

endmodule

// File: rtl/strobe_timer.sv
module strobe_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int CH_W         = 3,
  parameter int DATA_W       = 8,
  parameter int CONV_LOW_CYC = 2,
  parameter int RD_LOW_CYC   = 3,
  parameter int RD_GAP_CYC   = 2,
  parameter int TIMEOUT_CYC  = 40,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [1:0]        link_mode,
  output logic              busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              timeout,
  output logic              adc_convst_n,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic [CH_W-1:0]   adc_addr,
  input  logic              adc_eoc_n,
  input  logic [DATA_W-1:0] adc_db
);

  localparam int MAX_A  = (CONV_LOW_CYC > RD_LOW_CYC) ? CONV_LOW_CYC : RD_LOW_CYC;
  localparam int MAX_B  = (RD_GAP_CYC > TIMEOUT_CYC) ? RD_GAP_CYC : TIMEOUT_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] LD_CONV = CNT_W'(CONV_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] LD_GAP  = CNT_W'(RD_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TO   = CNT_W'(TIMEOUT_CYC - 1);

  rd_state_e         state_q;
  logic [1:0]        mode_q;
  logic [CH_W-1:0]   cur_chan_q;
  logic [CH_W-1:0]   prod_chan_q;
  logic [DATA_W-1:0] data_q;
  logic              seen_fall_q;

  logic              eoc_fall, eoc_rise;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              tied, mode_eff_cs_low;
  logic [1:0]        mode_eff;
  logic              rd_start, tied_done, rd_next_low;

  eoc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .eoc_n_async (adc_eoc_n),
    .fall        (eoc_fall),
    .rise        (eoc_rise)
  );

  strobe_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign tied            = (mode_q == LINK_TIED);
  assign mode_eff        = (state_q == ST_IDLE) ? link_mode : mode_q;
  assign mode_eff_cs_low = (mode_eff == LINK_CS_LOW);
  assign rd_start        = (state_q == ST_WAIT) && !tied && eoc_fall;
  assign tied_done       = (state_q == ST_WAIT) && tied && seen_fall_q && eoc_rise;
  assign rd_next_low     = rd_start || ((state_q == ST_READ) && !tmr_zero);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        tmr_load = 1'b1;
        tmr_val  = LD_CONV;
      end
      ST_CONV: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = LD_TO;
      end
      ST_WAIT: if (rd_start) begin
        tmr_load = 1'b1;
        tmr_val  = LD_RD;
      end else if (tied_done) begin
        tmr_load = 1'b1;
        tmr_val  = LD_GAP;
      end
      ST_READ: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = LD_GAP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_q       <= LINK_FULL;
      cur_chan_q   <= '0;
      prod_chan_q  <= '0;
      data_q       <= '0;
      seen_fall_q  <= 1'b0;
      busy         <= 1'b0;
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_chan     <= '0;
      timeout      <= 1'b0;
      adc_convst_n <= 1'b1;
      adc_cs_n     <= 1'b1;
      adc_rd_n     <= 1'b1;
      adc_addr     <= '0;
    end else begin
      res_valid <= 1'b0;
      timeout   <= 1'b0;
      adc_rd_n  <= !rd_next_low;
      if (mode_eff_cs_low) begin
        adc_cs_n <= 1'b0;
      end else if (mode_eff == LINK_TIED) begin
        adc_cs_n <= 1'b1;
      end else begin
        adc_cs_n <= !rd_next_low;
      end

      unique case (state_q)
        ST_IDLE: begin
          if (req) begin
            state_q      <= ST_CONV;
            mode_q       <= link_mode;
            adc_addr     <= req_chan;
            adc_convst_n <= 1'b0;
            busy         <= 1'b1;
          end
        end
        ST_CONV: begin
          if (tmr_zero) begin
            state_q      <= ST_WAIT;
            adc_convst_n <= 1'b1;
            seen_fall_q  <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (rd_start) begin
            state_q     <= ST_READ;
            prod_chan_q <= cur_chan_q;
            cur_chan_q  <= adc_addr;
          end else if (tied_done) begin
            state_q <= ST_GAP;
            data_q  <= adc_db;
          end else if (tied && eoc_fall) begin
            seen_fall_q <= 1'b1;
            prod_chan_q <= cur_chan_q;
            cur_chan_q  <= adc_addr;
          end else if (tmr_zero && !(tied && seen_fall_q)) begin
            state_q <= ST_IDLE;
            timeout <= 1'b1;
            busy    <= 1'b0;
          end
        end
        ST_READ: begin
          if (tmr_zero) begin
            state_q <= ST_GAP;
            data_q  <= adc_db;
          end
        end
        ST_GAP: begin
          if (tmr_zero) begin
            state_q   <= ST_IDLE;
            res_valid <= 1'b1;
            res_data  <= data_q;
            res_chan  <= prod_chan_q;
            busy      <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Address must not move while a transaction owns it.
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(adc_addr));

  // A request arriving mid-transaction must not retarget the link style.
  assert_busy_req_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && req) |=> $stable(mode_q));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_no_strobe_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(!adc_convst_n && !adc_rd_n));

  assert_cs_held_low_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == LINK_CS_LOW) |-> !adc_cs_n);

  assert_tied_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == LINK_TIED) |-> (adc_rd_n && adc_cs_n));

  assert_done_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && timeout));

endmodule

// File: tb/adc_rd_ctrl_test.sv
module adc_rd_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int CH_W = 3;
  localparam int DW   = 8;
  localparam int CONV_LOW = 2;
  localparam int RD_LOW   = 3;
  localparam int RD_GAP   = 2;
  localparam int TMO      = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [CH_W-1:0] req_chan = '0;
  logic [1:0] link_mode = 2'd0;
  logic busy, res_valid, timeout, adc_convst_n, adc_cs_n, adc_rd_n;
  logic [DW-1:0] res_data;
  logic [CH_W-1:0] res_chan, adc_addr;
  logic adc_eoc_n = 1'b1;
  logic [DW-1:0] adc_db = '0;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  // responder / model state
  logic [CH_W-1:0] conv_sel = '0;
  logic [4:0] salt = '0;
  bit resp_on = 1'b1;
  bit force_low = 1'b0;
  int resp_delay = 1;
  int wait_cnt = 0;
  bit armed = 1'b0;
  int eoc_low_cnt = 0;
  logic prev_cv = 1'b1, prev_rd = 1'b1;
  int cur_mode = 0;
  logic [CH_W-1:0] exp_addr = '0;
  logic [CH_W-1:0] exp_prev = '0;
  int conv_count = 0;
  int cv_run = 0, rd_run = 0;
  int rd_rise_cyc = 0, cv_rise_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_rd_ctrl #(
    .CH_W(CH_W), .DATA_W(DW), .CONV_LOW_CYC(CONV_LOW), .RD_LOW_CYC(RD_LOW),
    .RD_GAP_CYC(RD_GAP), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst(rst), .req(req), .req_chan(req_chan), .link_mode(link_mode),
    .busy(busy), .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .timeout(timeout), .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n),
    .adc_rd_n(adc_rd_n), .adc_addr(adc_addr), .adc_eoc_n(adc_eoc_n), .adc_db(adc_db)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_data(input logic [CH_W-1:0] ch, input logic [4:0] s);
    return {ch, s};
  endfunction

  // converter responder and strobe monitors
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (eoc_low_cnt > 0) eoc_low_cnt--;
      if (prev_cv && !adc_convst_n) begin
        armed = 1'b1;
        wait_cnt = resp_delay;
      end
      if (armed) begin
        if (wait_cnt == 0) begin
          armed = 1'b0;
          if (resp_on) begin
            adc_db = exp_data(conv_sel, salt);
            eoc_low_cnt = 6;
            if (cur_mode == 2) begin
              chk(adc_addr == exp_addr, "R5 tied addr", int'(adc_addr), int'(exp_addr));
              conv_sel = adc_addr;
            end
          end
        end else begin
          wait_cnt--;
        end
      end
      if (prev_rd && !adc_rd_n) begin
        chk(adc_addr == exp_addr, "R5 addr at read fall", int'(adc_addr), int'(exp_addr));
        conv_sel = adc_addr;
      end
      if (!prev_rd && adc_rd_n) eoc_low_cnt = 0;
      adc_eoc_n = !(force_low || eoc_low_cnt > 0);

      if (!adc_convst_n) cv_run++;
      else if (cv_run > 0) begin
        chk(cv_run == CONV_LOW, "R3 convst width", cv_run, CONV_LOW);
        cv_run = 0;
        conv_count++;
        cv_rise_cyc = cyc;
      end
      if (!adc_rd_n) rd_run++;
      else if (rd_run > 0) begin
        chk(rd_run == RD_LOW, "R4 read width", rd_run, RD_LOW);
        rd_run = 0;
        rd_rise_cyc = cyc;
      end
      if (res_valid && cur_mode != 2)
        chk(cyc - rd_rise_cyc == RD_GAP, "R7 gap before valid", cyc - rd_rise_cyc, RD_GAP);
      if (timeout)
        chk(cyc - cv_rise_cyc == TMO, "R10 timeout distance", cyc - cv_rise_cyc, TMO);
    end
    prev_cv = adc_convst_n;
    prev_rd = adc_rd_n;
  end

  task automatic txn(input logic [CH_W-1:0] ch, input int mode, input int delay,
                     input bit exp_to, input bit inject);
    bit got = 1'b0;
    bit tob = 1'b0;
    int start_conv;
    salt = 5'($urandom);
    resp_delay = delay;
    cur_mode = mode;
    exp_addr = ch;
    start_conv = conv_count;
    @(negedge clk);
    req = 1'b1; req_chan = ch; link_mode = 2'(mode);
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      req = (inject && k == 3);
      if (inject && k == 3) req_chan = ~ch;
      if (busy && mode == 1) chk(adc_cs_n == 1'b0, "R8 cs held low", int'(adc_cs_n), 0);
      if (busy && mode == 2) chk(adc_rd_n && adc_cs_n, "R9 no read strobe", int'(adc_rd_n), 1);
      if (busy && (mode == 0 || mode == 3))
        chk(adc_cs_n == adc_rd_n, "R4 R11 cs follows rd", int'(adc_cs_n), int'(adc_rd_n));
      if (res_valid) begin got = 1'b1; break; end
      if (timeout) begin tob = 1'b1; break; end
    end
    req = 1'b0;
    chk(busy == 1'b0, "R2 R7 busy drops with done", int'(busy), 0);
    if (exp_to) begin
      chk(tob && !got, "R10 timeout raised", int'(tob), 1);
    end else begin
      chk(got, "R7 valid seen", int'(got), 1);
      chk(res_data == exp_data(exp_prev, salt), "R6 result data",
          int'(res_data), int'(exp_data(exp_prev, salt)));
      chk(res_chan == exp_prev, "R5 R1 result channel", int'(res_chan), int'(exp_prev));
      exp_prev = ch;
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 valid one cycle", int'(res_valid), 0);
    repeat (10) @(negedge clk);
    chk(conv_count - start_conv == 1, "R2 one start per request", conv_count - start_conv, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A1C));
    repeat (4) @(negedge clk);
    chk(adc_convst_n && adc_rd_n && adc_cs_n, "R1 strobes high in reset", 0, 1);
    chk(!busy && !res_valid && !timeout, "R1 status low in reset", int'(busy), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(adc_convst_n && adc_rd_n && adc_cs_n && !busy, "R1 idle after reset", 0, 1);

    // directed
    txn(3'd5, 0, 2, 1'b0, 1'b0);   // first result reports channel 0
    txn(3'd2, 0, 0, 1'b0, 1'b0);
    txn(3'd7, 1, 4, 1'b0, 1'b0);
    txn(3'd1, 2, 3, 1'b0, 1'b0);
    txn(3'd6, 3, 5, 1'b0, 1'b0);
    txn(3'd4, 0, 6, 1'b0, 1'b1);   // request injected while busy

    resp_on = 1'b0;
    txn(3'd3, 0, 1, 1'b1, 1'b0);   // no completion at all
    force_low = 1'b1;              // stale low line, fall happens while idle
    repeat (8) @(negedge clk);
    txn(3'd2, 0, 1, 1'b1, 1'b0);
    force_low = 1'b0;
    resp_on = 1'b1;
    repeat (6) @(negedge clk);
    txn(3'd0, 2, 2, 1'b0, 1'b0);

    // constrained random
    for (int i = 0; i < 24; i++) begin
      txn(3'($urandom % 8), int'($urandom % 4), 1 + int'($urandom % 15), 1'b0, ($urandom % 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule